// File: doc/BRIEF.md
# Fractional-Step Periodic Interrupt Timer

This block runs a free counter and raises an interrupt at a period that need not be a whole number of counter ticks. The period is held as an integer step and a 32-bit binary fraction. Each acknowledged interrupt moves a stored compare value forward by the integer step. A fraction accumulator adds one extra tick whenever it wraps. Rounding error therefore never builds up, and the average spacing equals the programmed non-integer period.

The next compare value is always derived from the stored copy of the previous one and never from the live counter. The time software takes to answer an interrupt therefore has no effect on when the following one fires. Software writes both steps directly. It can also have them produced by a built-in restoring divider, which takes two normalized 31-bit mantissas and a power-of-two exponent difference and delivers the quotient as integer and fraction parts. For example, a 15.005 MHz counter with a 10 kHz interrupt rate gives 1500.5. Dropping the half tick would make the timer run fast by roughly 333 ppm.

Top module: `fit_timer_top`

## Requirements
- R1: After synchronous reset, count_out is 0 and irq, div_busy and div_done are 0.
- R2: count_out increases by one every clock cycle and wraps modulo 2^32.
- R3: A cycle with tmr_init high sets the compare value to (count_out in that cycle + integer step) and the fraction accumulator to the fractional step. It clears irq and arms the timer. tmr_init takes priority over irq_ack in the same cycle.
- R4: irq stays low until the first tmr_init. Once armed, irq rises in the cycle after the one where count_out equals the compare value, and it stays high until acknowledged.
- R5: irq_ack while irq is high drops irq in the next cycle. In the same step, the fraction accumulator adds the fractional step modulo 2^32, and the compare value advances by the integer step plus one when that addition carried out. With step 20 and fraction 0x40000000, successive interrupts are 20, 20, 21, 20, 20, 20, 21 ticks apart.
- R6: irq_ack while irq is low has no effect. Later interrupt times are unchanged.
- R7: step_int_we or step_frac_we loads step_wdata into the integer or the fractional step respectively.
- R8: A divider result is copied into both steps in the cycle after div_done. A register write to one step in that same cycle wins for that step.
- R9: div_start while the divider is idle raises div_busy from the next cycle for exactly div_shift+33 cycles. div_done then pulses for one cycle as div_busy falls. div_start while busy is ignored.
- R10: With div_num and div_den having bit 30 set, the integer step becomes floor(div_num·2^div_shift / div_den) and the fractional step becomes the next 32 quotient bits. Inputs 1920640000 / 1310720000 with shift 10 give 1500 and 0x80000000, so the spacing alternates 1501, 1500, 1501.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_int_we | input | 1 | Write strobe for the integer step |
| step_frac_we | input | 1 | Write strobe for the fractional step |
| step_wdata | input | 32 | Data for step writes |
| tmr_init | input | 1 | Load compare from the counter and arm |
| irq_ack | input | 1 | Acknowledge; advances the compare value |
| div_start | input | 1 | Start the step divider |
| div_num | input | 31 | Normalized dividend mantissa |
| div_den | input | 31 | Normalized divisor mantissa |
| div_shift | input | 5 | Exponent difference (integer quotient bits minus one) |
| div_busy | output | 1 | Divider running |
| div_done | output | 1 | One-cycle divider completion pulse |
| count_out | output | 32 | Free-running counter |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the carry of the fraction accumulator. A design that drops the carry or applies it one update late shows 20-tick gaps where 21 is due, or shifts where the half tick lands in the divider case. It tests an init that arrives together with an acknowledge. A design that lets the acknowledge win would advance from the old compare value instead of reloading from the counter. It sends stray acknowledges while irq is low, which a design that does not gate the update on a pending interrupt would turn into early or missing interrupts. It checks the divider's exact-quotient case and its busy length, and makes a step write collide with the divider result. A strict-compare divider would return 0x7FFFFFFF instead of one half, and a write that loses the collision would leave the wrong period.

// File: rtl/fit_pkg.sv
package fit_pkg;
  typedef enum logic [1:0] {
    DV_IDLE = 2'd0,
    DV_INT  = 2'd1,
    DV_FRAC = 2'd2
  } div_phase_e;
endpackage

// File: rtl/fit_free_counter.sv
module fit_free_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end
endmodule

// File: rtl/fit_step_divider.sv
module fit_step_divider
  import fit_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int FRAC_W = 32,
  parameter int MANT_W = 31,
  parameter int SH_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MANT_W-1:0] num,
  input  logic [MANT_W-1:0] den,
  input  logic [SH_W-1:0]   shift,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  q_int,
  output logic [FRAC_W-1:0] q_frac
);
  localparam int RW    = MANT_W + 2;
  localparam int SHMAX = 1 << SH_W;
  localparam int BPMAX = (FRAC_W > SHMAX) ? FRAC_W : SHMAX;
  localparam int BP_W  = $clog2(BPMAX);

  div_phase_e      phase;
  logic [RW-1:0]   rem;
  logic [RW-1:0]   den_ext;
  logic [BP_W-1:0] bitpos;
  logic            take;
  logic [RW-1:0]   diff;

  assign take = (rem >= den_ext);
  assign diff = take ? (rem - den_ext) : rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= DV_IDLE;
      rem     <= '0;
      den_ext <= '0;
      bitpos  <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      q_int   <= '0;
      q_frac  <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        DV_IDLE: begin
          if (start) begin
            rem     <= {2'b00, num};
            den_ext <= {2'b00, den};
            q_int   <= '0;
            q_frac  <= '0;
            bitpos  <= BP_W'(shift);
            busy    <= 1'b1;
            phase   <= DV_INT;
          end
        end
        DV_INT: begin
          if (take) q_int <= q_int | (CNT_W'(1) << bitpos);
          rem <= {diff[RW-2:0], 1'b0};
          if (bitpos == '0) begin
            bitpos <= BP_W'(FRAC_W - 1);
            phase  <= DV_FRAC;
          end else begin
            bitpos <= bitpos - 1'b1;
          end
        end
        DV_FRAC: begin
          if (take) q_frac <= q_frac | (FRAC_W'(1) << bitpos);
          rem <= {diff[RW-2:0], 1'b0};
          if (bitpos == '0) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            phase <= DV_IDLE;
          end else begin
            bitpos <= bitpos - 1'b1;
          end
        end
        default: phase <= DV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fit_compare_unit.sv
module fit_compare_unit #(
  parameter int CNT_W  = 32,
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              ack,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  step_int,
  input  logic [FRAC_W-1:0] step_frac,
  output logic [CNT_W-1:0]  saved,
  output logic [FRAC_W-1:0] frac_acc,
  output logic              irq
);
  logic              armed;
  logic              hit;
  logic [FRAC_W:0]   frac_sum;

  assign hit      = armed & (count == saved);
  assign frac_sum = {1'b0, frac_acc} + {1'b0, step_frac};

  always_ff @(posedge clk) begin
    if (rst) begin
      saved    <= '0;
      frac_acc <= '0;
      armed    <= 1'b0;
      irq      <= 1'b0;
    end else if (init) begin
      saved    <= count + step_int;
      frac_acc <= step_frac;
      armed    <= 1'b1;
      irq      <= 1'b0;
    end else begin
      if (ack && irq) begin
        frac_acc <= frac_sum[FRAC_W-1:0];
        saved    <= saved + step_int + CNT_W'(frac_sum[FRAC_W]);
      end
      irq <= hit | (irq & ~ack);
    end
  end
endmodule

// File: rtl/fit_timer_top.sv
module fit_timer_top #(
  parameter int CNT_W  = 32,
  parameter int FRAC_W = 32,
  parameter int MANT_W = 31,
  parameter int SH_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_int_we,
  input  logic              step_frac_we,
  input  logic [CNT_W-1:0]  step_wdata,
  input  logic              tmr_init,
  input  logic              irq_ack,
  input  logic              div_start,
  input  logic [MANT_W-1:0] div_num,
  input  logic [MANT_W-1:0] div_den,
  input  logic [SH_W-1:0]   div_shift,
  output logic              div_busy,
  output logic              div_done,
  output logic [CNT_W-1:0]  count_out,
  output logic              irq
);
  logic [CNT_W-1:0]  step_int;
  logic [FRAC_W-1:0] step_frac;
  logic [CNT_W-1:0]  q_int;
  logic [FRAC_W-1:0] q_frac;
  logic [CNT_W-1:0]  saved_w;
  logic [FRAC_W-1:0] frac_acc_w;

  fit_free_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .count(count_out)
  );

  fit_step_divider #(
    .CNT_W(CNT_W), .FRAC_W(FRAC_W), .MANT_W(MANT_W), .SH_W(SH_W)
  ) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(div_den),
    .shift(div_shift), .busy(div_busy), .done(div_done),
    .q_int(q_int), .q_frac(q_frac)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step_int  <= '0;
      step_frac <= '0;
    end else begin
      if (step_int_we)   step_int  <= step_wdata;
      else if (div_done) step_int  <= q_int;
      if (step_frac_we)  step_frac <= FRAC_W'(step_wdata);
      else if (div_done) step_frac <= q_frac;
    end
  end

  fit_compare_unit #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_cmp (
    .clk(clk), .rst(rst), .init(tmr_init), .ack(irq_ack), .count(count_out),
    .step_int(step_int), .step_frac(step_frac), .saved(saved_w),
    .frac_acc(frac_acc_w), .irq(irq)
  );
endmodule

// File: rtl/fit_timer_checks.sv
module fit_timer_checks #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tmr_init,
  input logic             irq_ack,
  input logic             irq,
  input logic [CNT_W-1:0] count_out,
  input logic [CNT_W-1:0] saved_w,
  input logic [CNT_W-1:0] step_int,
  input logic             div_busy,
  input logic             div_done
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> count_out == $past(count_out) + 1'b1); // R2
  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (rst)
    tmr_init |=> saved_w == $past(count_out) + $past(step_int)); // R3
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack && !tmr_init) |=> irq); // R4
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (irq && irq_ack && !tmr_init) |=> !irq); // R5
  AST_SAVED_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (irq && irq_ack && !tmr_init) |=>
      (saved_w - $past(saved_w) - $past(step_int)) <= CNT_W'(1)); // R5
  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (rst)
    (!irq && !tmr_init) |=> $stable(saved_w)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    div_done |=> !div_done); // R9
  AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
    $fell(div_busy) |-> div_done); // R9
endmodule

bind fit_timer_top fit_timer_checks #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tmr_init(tmr_init), .irq_ack(irq_ack), .irq(irq),
  .count_out(count_out), .saved_w(saved_w), .step_int(step_int),
  .div_busy(div_busy), .div_done(div_done)
);

// File: tb/tb_fit_timer_top.sv
module tb_fit_timer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_int_we = 0, step_frac_we = 0;
  logic [31:0] step_wdata = '0;
  logic        tmr_init = 0, irq_ack = 0, div_start = 0;
  logic [30:0] div_num = '0, div_den = '0;
  logic [4:0]  div_shift = '0;
  logic        div_busy, div_done, irq;
  logic [31:0] count_out;

  int total = 0, bad = 0, cycles = 0;
  bit model_on = 0;

  always #5 clk = ~clk;

  fit_timer_top dut (
    .clk(clk), .rst(rst), .step_int_we(step_int_we), .step_frac_we(step_frac_we),
    .step_wdata(step_wdata), .tmr_init(tmr_init), .irq_ack(irq_ack),
    .div_start(div_start), .div_num(div_num), .div_den(div_den),
    .div_shift(div_shift), .div_busy(div_busy), .div_done(div_done),
    .count_out(count_out), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference
  logic [31:0] m_cnt, m_int, m_frac, m_saved, m_rem, m_qi, m_qf;
  bit m_armed, m_irq, m_done;
  int m_left;

  task automatic div_ref(input longint n, input longint d, input int sh,
                         output logic [31:0] qi, output logic [31:0] qf);
    longint r = n;
    qi = 0; qf = 0;
    for (int i = sh; i >= 0; i--) begin
      if (r >= d) begin qi[i] = 1'b1; r = r - d; end
      r = r * 2;
    end
    for (int i = 31; i >= 0; i--) begin
      if (r >= d) begin qf[i] = 1'b1; r = r - d; end
      r = r * 2;
    end
  endtask

  always @(posedge clk) begin
    bit hit, irq_n, done_n;
    logic [32:0] s;
    if (rst) begin
      m_cnt = 0; m_int = 0; m_frac = 0; m_saved = 0; m_rem = 0; m_qi = 0; m_qf = 0;
      m_armed = 0; m_irq = 0; m_done = 0; m_left = 0;
    end else begin
      hit = m_armed && (m_cnt == m_saved);
      irq_n = hit || (m_irq && !irq_ack);
      if (tmr_init) begin
        m_saved = m_cnt + m_int; m_rem = m_frac; m_armed = 1; irq_n = 0;
      end else if (irq_ack && m_irq) begin
        s = {1'b0, m_rem} + {1'b0, m_frac};
        m_rem = s[31:0];
        m_saved = m_saved + m_int + {31'b0, s[32]};
      end
      m_irq = irq_n;
      if (step_int_we) m_int = step_wdata; else if (m_done) m_int = m_qi;
      if (step_frac_we) m_frac = step_wdata; else if (m_done) m_frac = m_qf;
      done_n = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) done_n = 1;
      end else if (div_start) begin
        div_ref(longint'(div_num), longint'(div_den), int'(div_shift), m_qi, m_qf);
        m_left = int'(div_shift) + 33;
      end
      m_done = done_n;
      m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      check(count_out == m_cnt, "R2 counter", count_out, m_cnt);
      check(irq == m_irq, "R4 irq vs model", irq, m_irq);
      check(div_busy == (m_left > 0), "R9 busy vs model", div_busy, m_left > 0);
      check(div_done == m_done, "R9 done vs model", div_done, m_done);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // wait for an interrupt, note count, acknowledge it
  task automatic serve(output logic [31:0] c);
    int n = 0;
    @(negedge clk);
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    c = count_out;
    irq_ack = 1; @(negedge clk); irq_ack = 0;
  endtask

  task automatic do_init(output logic [31:0] c);
    @(negedge clk); c = count_out; tmr_init = 1;
    @(negedge clk); tmr_init = 0;
  endtask

  initial begin
    logic [31:0] c0, c1, c2;
    int gaps_a[7] = '{20, 20, 21, 20, 20, 20, 21};
    int gaps_b[3] = '{1501, 1500, 1501};
    int nb;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state (first cycle after release shows reset values then counts)
    check(irq == 0 && div_busy == 0 && div_done == 0, "R1 reset flags", {irq, div_busy, div_done}, 0);
    check(count_out == 1, "R1 counter from zero", count_out, 1);
    model_on = 1;
    // R4: no interrupt before the first init
    repeat (60) begin @(negedge clk); if (irq) break; end
    check(irq == 0, "R4 unarmed", irq, 0);

    // R7: direct step writes
    step_int_we = 1; step_frac_we = 1; step_wdata = 32'd20;
    @(negedge clk); step_frac_we = 0; step_int_we = 0;
    step_frac_we = 1; step_wdata = 32'h4000_0000;
    @(negedge clk); step_frac_we = 0;
    do_init(c0);
    serve(c1);
    check(c1 == c0 + 21, "R3 first interrupt", c1, c0 + 21);
    check(c1 == c0 + 21, "R7 written step used", c1 - c0, 21);
    for (int i = 0; i < 7; i++) begin
      if (i == 2) begin
        // R4: hold without ack
        @(negedge clk);
        while (!irq) @(negedge clk);
        c2 = count_out;
        repeat (5) @(negedge clk);
        check(irq == 1, "R4 held until ack", irq, 1);
        irq_ack = 1; @(negedge clk); irq_ack = 0;
        check(irq == 0, "R5 ack drops irq", irq, 0);
      end else begin
        if (i >= 4) begin
          // R6: stray ack while irq low
          repeat (3) @(negedge clk);
          irq_ack = 1; @(negedge clk); irq_ack = 0;
        end
        serve(c2);
      end
      check(c2 - c1 == gaps_a[i], (i >= 4) ? "R6 stray ack gap" : "R5 fractional gap",
            c2 - c1, gaps_a[i]);
      c1 = c2;
    end
    // R3/R11 style: init together with ack while irq high
    @(negedge clk);
    while (!irq) @(negedge clk);
    c0 = count_out; tmr_init = 1; irq_ack = 1;
    @(negedge clk); tmr_init = 0; irq_ack = 0;
    check(irq == 0, "R3 init clears irq", irq, 0);
    serve(c1);
    check(c1 == c0 + 21, "R3 init wins over ack", c1, c0 + 21);

    // R9/R10: divider example 1500.5
    div_num = 31'd1920640000; div_den = 31'd1310720000; div_shift = 5'd10;
    @(negedge clk); div_start = 1;
    @(negedge clk); div_start = 0; nb = 0;
    while (div_busy && nb < 200) begin
      nb++;
      if (nb == 5) div_start = 1; // ignored while busy
      @(negedge clk);
      div_start = 0;
    end
    check(nb == 43, "R9 busy length", nb, 43);
    check(div_done == 1, "R9 done with busy fall", div_done, 1);
    repeat (2) @(negedge clk);
    do_init(c0);
    serve(c1);
    check(c1 == c0 + 1501, "R10 integer step", c1, c0 + 1501);
    for (int i = 0; i < 3; i++) begin
      serve(c2);
      check(c2 - c1 == gaps_b[i], "R10 half-tick spacing", c2 - c1, gaps_b[i]);
      c1 = c2;
    end

    // R8: write collides with divider result (12.0 from divider, int overwritten with 7)
    div_num = 31'h6000_0000; div_den = 31'h4000_0000; div_shift = 5'd3;
    @(negedge clk); div_start = 1;
    @(negedge clk); div_start = 0;
    while (!div_done) @(negedge clk);
    step_int_we = 1; step_wdata = 32'd7;
    @(negedge clk); step_int_we = 0;
    do_init(c0);
    serve(c1);
    check(c1 == c0 + 8, "R8 write wins for integer", c1, c0 + 8);
    for (int i = 0; i < 3; i++) begin
      serve(c2);
      check(c2 - c1 == 7, "R8 divider fraction zero", c2 - c1, 7);
      c1 = c2;
    end
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule